// File: doc/BRIEF.md
# Load Result Extender with Condition Codes

This block is the write-back end of the load path in a 32-bit processor whose bits are numbered 0 at the most significant end through 31 at the least significant end. Each cycle it may accept one load of four classes: immediate, byte, halfword or word. From the instruction's 20-bit value field, or from the effective memory word and the low address bits, it builds the 32-bit value for the destination register and raises a write enable.

With each accepted load it also computes the two low condition code bits, called CC3 and CC4 here. Immediate, halfword and word loads report zero, negative or positive. Byte loads are zero-extended, so they report only zero or nonzero. The block holds the current CC3/CC4 pair itself. The upper condition bits are outside it and are never touched.

An immediate load that is marked indirectly addressed is not a legal instruction. The block raises a trap request carrying vector 0x40 and leaves the register value and the condition bits as they were. A halfword load at an odd address raises an alignment error, and nothing is written. All outputs are registered one cycle after the input is presented.

Top module: `load_result_unit`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `wr_en`, `cc_upd`, `trap_req`, `align_err`, `wr_data` and `trap_vec` are 0, and `cc34` is 00.
- R2: An immediate load (`op_class` 0) writes `imm_field` with its bit 19 (instruction bit 12) copied into the twelve result bits above it.
- R3: A byte load (`op_class` 1) writes the byte chosen by `addr_lo` into `wr_data[7:0]` and zeros `wr_data[31:8]`. `addr_lo` 0 picks `mem_word[31:24]` and 3 picks `mem_word[7:0]`.
- R4: A halfword load (`op_class` 2) writes the halfword chosen by `addr_lo[1]`, with its sign copied into the 16 upper bits. 0 picks `mem_word[31:16]`.
- R5: A word load (`op_class` 3) writes `mem_word` unchanged.
- R6: For immediate, halfword and word loads, `cc34` becomes 00 for a zero result, 01 when `wr_data[31]` is 1, and 10 otherwise.
- R7: For byte loads, `cc34` becomes 00 for a zero result and 10 for any nonzero result, including bytes whose top bit is set. The value 01 never results.
- R8: `cc34` changes only on a successful load, which is signalled by `cc_upd`. It holds while `in_valid` is low, and it is never 11.
- R9: An immediate load with `indirect` high raises `trap_req` with `trap_vec` = 0x40. `wr_en` and `cc_upd` stay low, and `cc34` and `wr_data` keep their values.
- R10: A halfword load with `addr_lo[0]` = 1 raises `align_err`. `wr_en` and `cc_upd` stay low, and `cc34` is unchanged.
- R11: `wr_en` is never high together with `trap_req`. The `indirect` flag has no effect on byte, halfword and word loads.
- R12: Results appear exactly one cycle after the input is presented. `wr_en`, `cc_upd`, `trap_req` and `align_err` are high for one cycle per accepted input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | A load is presented this cycle |
| op_class | input | 2 | 0 immediate, 1 byte, 2 halfword, 3 word |
| imm_field | input | 20 | Instruction value field (instruction bits 12-31) |
| mem_word | input | 32 | Effective memory word |
| addr_lo | input | 2 | Low bits of the effective byte address |
| indirect | input | 1 | Instruction is indirectly addressed |
| wr_en | output | 1 | Register write enable |
| wr_data | output | 32 | Register write value |
| cc_upd | output | 1 | CC3/CC4 updated this cycle |
| cc34 | output | 2 | Current CC3/CC4 pair |
| trap_req | output | 1 | Nonexistent-instruction trap request |
| trap_vec | output | 8 | Trap vector, 0x40 when requested |
| align_err | output | 1 | Misaligned halfword load |

## Verification
The assertions assume that `in_valid`, `op_class` and the data inputs are stable at the clock edge and are sampled only while `rst` is low. Their hold checks rely on `cc34` and `wr_data` having a defined value from reset. The bench changes inputs only on falling edges. It applies every load class at every address offset, including odd halfword offsets and the indirect flag on each class, and keeps `in_valid` low on some cycles so that the hold behaviour is also exercised.

// File: rtl/ldx_pkg.sv
package ldx_pkg;
  typedef enum logic [1:0] {
    OP_LI = 2'd0,
    OP_LB = 2'd1,
    OP_LH = 2'd2,
    OP_LW = 2'd3
  } ld_op_e;

  localparam logic [1:0] CC_ZERO = 2'b00;
  localparam logic [1:0] CC_NEG  = 2'b01;
  localparam logic [1:0] CC_POS  = 2'b10;
endpackage

// File: rtl/ldx_align.sv
module ldx_align #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 2
) (
  input  logic [DATA_W-1:0] word,
  input  logic [ADDR_W-1:0] addr,
  output logic [7:0]        byte_sel,
  output logic [15:0]       half_sel
);
  localparam int LANES  = DATA_W / 8;
  localparam int HALVES = DATA_W / 16;

  logic [7:0]  lane [LANES];
  logic [15:0] half [HALVES];

  // lane 0 is the most significant byte (big-endian numbering)
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane[g] = word[DATA_W-1-8*g -: 8];
  end
  for (genvar h = 0; h < HALVES; h++) begin : g_half
    assign half[h] = word[DATA_W-1-16*h -: 16];
  end

  assign byte_sel = lane[addr];
  assign half_sel = half[addr[ADDR_W-1:1]];
endmodule

// File: rtl/ldx_extend.sv
module ldx_extend
  import ldx_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 20
) (
  input  ld_op_e            op,
  input  logic [IMM_W-1:0]  imm,
  input  logic [7:0]        byte_sel,
  input  logic [15:0]       half_sel,
  input  logic [DATA_W-1:0] word,
  output logic [DATA_W-1:0] result
);
  always_comb begin
    unique case (op)
      OP_LI:   result = {{(DATA_W-IMM_W){imm[IMM_W-1]}}, imm};
      OP_LB:   result = {{(DATA_W-8){1'b0}}, byte_sel};
      OP_LH:   result = {{(DATA_W-16){half_sel[15]}}, half_sel};
      default: result = word;
    endcase
  end
endmodule

// File: rtl/ldx_ccgen.sv
module ldx_ccgen
  import ldx_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  ld_op_e            op,
  input  logic [DATA_W-1:0] result,
  output logic [1:0]        cc
);
  always_comb begin
    if (result == '0)           cc = CC_ZERO;
    else if (op == OP_LB)       cc = CC_POS;   // byte: nonzero only
    else if (result[DATA_W-1])  cc = CC_NEG;
    else                        cc = CC_POS;
  end
endmodule

// File: rtl/load_result_unit.sv
module load_result_unit
  import ldx_pkg::*;
#(
  parameter int          DATA_W   = 32,
  parameter int          IMM_W    = 20,
  parameter int          ADDR_W   = 2,
  parameter int          VEC_W    = 8,
  parameter logic [7:0]  TRAP_LOC = 8'h40
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [1:0]        op_class,
  input  logic [IMM_W-1:0]  imm_field,
  input  logic [DATA_W-1:0] mem_word,
  input  logic [ADDR_W-1:0] addr_lo,
  input  logic              indirect,
  output logic              wr_en,
  output logic [DATA_W-1:0] wr_data,
  output logic              cc_upd,
  output logic [1:0]        cc34,
  output logic              trap_req,
  output logic [VEC_W-1:0]  trap_vec,
  output logic              align_err
);
  ld_op_e            op;
  logic [7:0]        byte_sel;
  logic [15:0]       half_sel;
  logic [DATA_W-1:0] result;
  logic [1:0]        cc_next;
  logic              trap_c, mis_c, ok_c;
  ld_op_e            op_q;

  assign op = ld_op_e'(op_class);

  ldx_align #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_align (
    .word(mem_word), .addr(addr_lo), .byte_sel(byte_sel), .half_sel(half_sel)
  );

  ldx_extend #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_ext (
    .op(op), .imm(imm_field), .byte_sel(byte_sel), .half_sel(half_sel),
    .word(mem_word), .result(result)
  );

  ldx_ccgen #(.DATA_W(DATA_W)) u_cc (.op(op), .result(result), .cc(cc_next));

  assign trap_c = in_valid && (op == OP_LI) && indirect;
  assign mis_c  = in_valid && (op == OP_LH) && addr_lo[0];
  assign ok_c   = in_valid && !trap_c && !mis_c;

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_en     <= 1'b0;
      wr_data   <= '0;
      cc_upd    <= 1'b0;
      cc34      <= CC_ZERO;
      trap_req  <= 1'b0;
      trap_vec  <= '0;
      align_err <= 1'b0;
      op_q      <= OP_LI;
    end else begin
      wr_en     <= ok_c;
      cc_upd    <= ok_c;
      trap_req  <= trap_c;
      trap_vec  <= trap_c ? VEC_W'(TRAP_LOC) : '0;
      align_err <= mis_c;
      op_q      <= op;
      if (ok_c) begin
        wr_data <= result;
        cc34    <= cc_next;
      end
    end
  end

  AST_NO_WE_WITH_TRAP: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && trap_req)); // R11
  AST_CC_NEVER_11: assert property (@(posedge clk) disable iff (rst)
    cc34 != 2'b11); // R8
  AST_TRAP_KEEPS_STATE: assert property (@(posedge clk) disable iff (rst)
    trap_req |-> (cc34 == $past(cc34)) && (wr_data == $past(wr_data))); // R9
  AST_MISALIGN_KEEPS_CC: assert property (@(posedge clk) disable iff (rst)
    align_err |-> !wr_en && (cc34 == $past(cc34))); // R10
  AST_BYTE_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
    (wr_en && op_q == OP_LB) |-> (wr_data[DATA_W-1:8] == '0)); // R3
  AST_BYTE_NO_NEG: assert property (@(posedge clk) disable iff (rst)
    (cc_upd && op_q == OP_LB) |-> (cc34 != CC_NEG)); // R7
  AST_NEG_MEANS_SIGN: assert property (@(posedge clk) disable iff (rst)
    (cc_upd && cc34 == CC_NEG) |-> wr_data[DATA_W-1]); // R6
  AST_TRAP_VECTOR: assert property (@(posedge clk) disable iff (rst)
    trap_req |-> (trap_vec == VEC_W'(TRAP_LOC))); // R9
endmodule

// File: tb/test_load_result_unit.sv
`timescale 1ns/1ps
module test_load_result_unit;
  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic [1:0]  op_class;
  logic [19:0] imm_field;
  logic [31:0] mem_word;
  logic [1:0]  addr_lo;
  logic        indirect;
  logic        wr_en, cc_upd, trap_req, align_err;
  logic [31:0] wr_data;
  logic [1:0]  cc34;
  logic [7:0]  trap_vec;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  logic [31:0] e_data;
  logic [1:0]  e_cc;
  logic        e_we, e_upd, e_trap, e_mis;
  string       t_data, t_cc, t_ctl;

  always #2.5 clk = ~clk;

  load_result_unit i_load_result_unit (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op_class(op_class),
    .imm_field(imm_field), .mem_word(mem_word), .addr_lo(addr_lo),
    .indirect(indirect), .wr_en(wr_en), .wr_data(wr_data), .cc_upd(cc_upd),
    .cc34(cc34), .trap_req(trap_req), .trap_vec(trap_vec), .align_err(align_err)
  );

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // behavioural reference, evaluated at the clock edge on the applied inputs
  task automatic model();
    logic [31:0] r;
    int sh;
    e_we = 0; e_upd = 0; e_trap = 0; e_mis = 0;
    t_ctl = "R12";
    if (!in_valid) begin
      t_cc = "R8"; t_data = "R8";
      return;
    end
    if (op_class == 2'd0 && indirect) begin
      e_trap = 1; t_ctl = "R9"; t_cc = "R9"; t_data = "R9";
      return;
    end
    if (op_class == 2'd2 && addr_lo[0]) begin
      e_mis = 1; t_ctl = "R10"; t_cc = "R10"; t_data = "R10";
      return;
    end
    case (op_class)
      2'd0: begin
        r = {12'h000, imm_field};
        if (imm_field >= 20'h80000) r = r | 32'hFFF0_0000;
        t_data = "R2";
      end
      2'd1: begin
        sh = 8 * (3 - addr_lo);
        r = (mem_word >> sh) & 32'hFF;
        t_data = "R3";
      end
      2'd2: begin
        sh = addr_lo[1] ? 0 : 16;
        r = (mem_word >> sh) & 32'hFFFF;
        if (r >= 32'h8000) r = r + 32'hFFFF_0000;
        t_data = "R4";
      end
      default: begin r = mem_word; t_data = "R5"; end
    endcase
    if (indirect && op_class != 2'd0) t_data = {t_data, "/R11"};
    e_we = 1; e_upd = 1; e_data = r;
    if (op_class == 2'd1) begin
      t_cc = "R7";
      e_cc = (r == 0) ? 2'b00 : 2'b10;
    end else begin
      t_cc = "R6";
      if (r == 0) e_cc = 2'b00;
      else if (r >= 32'h8000_0000) e_cc = 2'b01;
      else e_cc = 2'b10;
    end
  endtask

  task automatic compare();
    chk(t_ctl, "wr_en", 32'(wr_en), 32'(e_we));
    chk(t_data, "wr_data", wr_data, e_data);
    chk(t_cc, "cc34", 32'(cc34), 32'(e_cc));
    chk(t_ctl, "cc_upd", 32'(cc_upd), 32'(e_upd));
    chk(e_trap ? "R9" : "R11", "trap_req", 32'(trap_req), 32'(e_trap));
    chk("R9", "trap_vec", 32'(trap_vec), e_trap ? 32'h40 : 32'h0);
    chk(e_mis ? "R10" : "R12", "align_err", 32'(align_err), 32'(e_mis));
  endtask

  task automatic step(logic v, logic [1:0] op, logic [19:0] imm,
                      logic [31:0] w, logic [1:0] a, logic ind);
    in_valid = v; op_class = op; imm_field = imm;
    mem_word = w; addr_lo = a; indirect = ind;
    @(posedge clk);
    model();
    @(negedge clk);
    compare();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst = 1; in_valid = 0; op_class = 0; imm_field = 0;
    mem_word = 0; addr_lo = 0; indirect = 0;
    e_data = 0; e_cc = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", "wr_en", 32'(wr_en), 0);
    chk("R1", "cc34", 32'(cc34), 0);
    chk("R1", "wr_data", wr_data, 0);
    chk("R1", "trap_req", 32'(trap_req), 0);
    rst = 0;
    step(0, 0, 0, 0, 0, 0);                  // R1 first cycle out of reset
    // R2 immediate, both signs and zero
    step(1, 0, 20'h7FFFF, 0, 0, 0);
    step(1, 0, 20'h80000, 0, 0, 0);
    step(1, 0, 20'h00000, 0, 0, 0);
    step(1, 0, 20'hFFFFF, 0, 0, 0);
    // R3/R7 byte at each lane, top bit set must read as nonzero
    for (int a = 0; a < 4; a++) step(1, 1, 0, 32'h80F1_0023, 2'(a), 0);
    // R4 halfword, both halves, plus misaligned R10
    for (int a = 0; a < 4; a++) step(1, 2, 0, 32'h8001_7FFE, 2'(a), 0);
    step(1, 2, 0, 32'h0000_FFFF, 2'd0, 0);
    // R5 word
    step(1, 3, 0, 32'h0000_0000, 0, 0);
    step(1, 3, 0, 32'hDEAD_BEEF, 0, 0);
    step(1, 3, 0, 32'h1234_5678, 0, 0);
    // R9 indirect immediate traps, state kept
    step(1, 0, 20'h00005, 0, 0, 1);
    step(0, 0, 0, 0, 0, 0);                  // R8 idle holds
    // R11 indirect ignored on other classes
    step(1, 1, 0, 32'h0000_00AB, 3, 1);
    step(1, 2, 0, 32'hFFFF_0000, 2, 1);
    step(1, 3, 0, 32'h8000_0000, 0, 1);
    // mixed stimulus, some idle cycles
    for (int i = 0; i < 400; i++)
      step(($urandom % 5) != 0, 2'($urandom), 20'($urandom),
           (($urandom % 6) == 0) ? 32'h0 : $urandom, 2'($urandom),
           ($urandom % 4) == 0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule